// File: doc/BRIEF.md
# Interrupt Router Register Window

This block holds the programmable state of an I/O interrupt router and exposes it to software through a two-word window. One word is an 8-bit index register. The other word reads or writes whichever internal register the index currently selects. The internal registers are a router identifier, a read-only capability word, an arbitration identifier, and a table of 64-bit redirection entries. Each table entry is reached as two 32-bit halves.

Every bus request is answered exactly one clock later with a response strobe. The strobe carries registered read data, or an error flag when the access is malformed. The whole redirection table is driven out in parallel on a flat vector so that the dispatch logic can read any entry without going through the window.

Top module: `irq_route_regs`

## Requirements
- R1: A request is malformed when its byte-enables are not 4'b1111 or when its byte offset is neither 0 nor 16. Its response has `rsp_err`=1 and `rsp_rdata`=0, and the request changes no register.
- R2: Every request with `req_valid`=1 is answered by `rsp_valid`=1 in the following cycle, and no response appears in a cycle without a request. Offset 0 is the index register: a write stores `req_wdata[7:0]`, and a read returns the index in bits 7:0 with zeros above.
- R3: Index 0x00 is the router ID. A write through offset 16 stores `req_wdata[27:24]`, and a read returns the stored ID in bits 27:24 with every other bit zero.
- R4: Index 0x01 reads (`NUM_ENT`-1) in bits 23:16 and `VERSION` in bits 7:0, which is 0x00170011 with the default parameters. Writes to index 0x01 change nothing.
- R5: Index 0x02 is the arbitration ID. It uses the bits 27:24 layout and is stored separately from the router ID.
- R6: Indices 0x10 to 0x10+2*`NUM_ENT`-1 select table entry n=(index-0x10)/2. An even index selects the low word, `tbl_flat[n*64 +: 32]`, and an odd index selects the high word, `tbl_flat[n*64+32 +: 32]`. Reads return the stored word.
- R7: Writing a low word clears its bits 31:17. Writing a high word clears its bits 23:0, so that only bits 31:24 (the destination byte) are kept.
- R8: Reset sets the index register to 0, sets the router ID and the arbitration ID to `CPU_COUNT`, and sets every table entry to zero.
- R9: Indices 0x03 to 0x0F, and indices above the last table index (0x40 and up by default), read as zero and ignore writes.
- R10: A well-formed write is answered with `rsp_err`=0 and `rsp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte offset within the window |
| req_be | input | 4 | Byte enables; only 4'b1111 is legal |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Malformed access flag |
| rsp_rdata | output | 32 | Registered read data |
| tbl_flat | output | NUM_ENT*64 | All redirection entries; entry n at bits n*64 +: 64 |

## Verification
The situations hardest to reach from the ports are the edges of the index decode: the last valid odd index (0x3F), the first index past the table (0x40), and a window write that is malformed only through its byte-enables while the index points at a live table entry. Each of these needs two bus transfers, first a write of the index and then the window access. The stimulus for the partial-enable case loads a known pattern into the entry first, so that the full `tbl_flat` snapshot shows whether a rejected write leaked into it. Undefined-index writes are followed by reads of the ID, arbitration ID and table, so that any stray update shows up at the ports.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int DW      = 32;
    localparam int SEL_W   = 8;
    localparam int ID_LSB  = 24;
    localparam int ID_W    = 4;
    localparam logic [SEL_W-1:0] TBL_BASE = 8'h10;

    // kept bits of each table half; everything else is reserved
    localparam logic [DW-1:0] LO_KEEP = 32'h0001_FFFF;
    localparam logic [DW-1:0] HI_KEEP = 32'hFF00_0000;

    typedef enum logic [1:0] {
        ACC_SEL,
        ACC_WIN,
        ACC_BAD
    } acc_kind_e;

    typedef enum logic [2:0] {
        IDX_ID,
        IDX_VER,
        IDX_ARB,
        IDX_TBL,
        IDX_NONE
    } idx_kind_e;

    typedef struct packed {
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
    } redir_ent_t;

    function automatic logic [DW-1:0] id_word(input logic [ID_W-1:0] v);
        logic [DW-1:0] w;
        w = '0;
        w[ID_LSB +: ID_W] = v;
        return w;
    endfunction

    function automatic logic [DW-1:0] scrub(input logic [DW-1:0] d, input logic hi);
        return hi ? (d & HI_KEEP) : (d & LO_KEEP);
    endfunction

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int NUM_ENT = 24,
    localparam int ENT_W  = $clog2(NUM_ENT)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be,
    input  logic [SEL_W-1:0]  sel,
    output acc_kind_e         acc,
    output idx_kind_e         idx,
    output logic [ENT_W-1:0]  ent,
    output logic              half_hi
);
    localparam logic [SEL_W-1:0] NUM_ENT_B = SEL_W'(NUM_ENT);
    localparam logic [ADDR_W-1:0] OFF_SEL  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_WIN  = ADDR_W'(16);

    logic [SEL_W-1:0] off;
    logic [SEL_W-1:0] ent_full;

    always_comb begin
        if (be != 4'b1111)       acc = ACC_BAD;
        else if (addr == OFF_SEL) acc = ACC_SEL;
        else if (addr == OFF_WIN) acc = ACC_WIN;
        else                      acc = ACC_BAD;
    end

    assign off      = sel - TBL_BASE;
    assign ent_full = {1'b0, off[SEL_W-1:1]};
    assign ent      = ent_full[ENT_W-1:0];
    assign half_hi  = off[0];

    always_comb begin
        unique case (sel)
            8'h00:   idx = IDX_ID;
            8'h01:   idx = IDX_VER;
            8'h02:   idx = IDX_ARB;
            default: idx = (sel >= TBL_BASE && ent_full < NUM_ENT_B) ? IDX_TBL : IDX_NONE;
        endcase
    end

endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
    import irq_route_pkg::*;
#(
    parameter int NUM_ENT = 24,
    localparam int ENT_W  = $clog2(NUM_ENT)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ENT_W-1:0]        ent,
    input  logic                    half_hi,
    input  logic [DW-1:0]           wdata,
    output logic [DW-1:0]           rdata,
    output logic [NUM_ENT*64-1:0]   flat
);
    redir_ent_t ent_q [NUM_ENT];

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[i] <= '0;
            end else if (wr_en && ent == ENT_W'(i)) begin
                if (half_hi) ent_q[i].hi <= scrub(wdata, 1'b1);
                else         ent_q[i].lo <= scrub(wdata, 1'b0);
            end
        end
        assign flat[i*64 +: 64] = ent_q[i];
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_ENT; k++) begin
            if (ent == ENT_W'(k)) rdata = half_hi ? ent_q[k].hi : ent_q[k].lo;
        end
    end

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_ENT   = 24,
    parameter int CPU_COUNT = 4,
    parameter logic [7:0] VERSION = 8'h11,
    localparam int ENT_W    = $clog2(NUM_ENT)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [3:0]            req_be,
    input  logic [31:0]           req_wdata,
    output logic                  rsp_valid,
    output logic                  rsp_err,
    output logic [31:0]           rsp_rdata,
    output logic [NUM_ENT*64-1:0] tbl_flat
);
    localparam logic [DW-1:0] VER_WORD = {8'h00, 8'(NUM_ENT - 1), 8'h00, VERSION};

    logic [SEL_W-1:0] sel_q;
    logic [ID_W-1:0]  id_q, arb_q;
    acc_kind_e        acc;
    idx_kind_e        idx;
    logic [ENT_W-1:0] ent;
    logic             half_hi;
    logic             wr_sel, wr_win, tbl_wr;
    logic [DW-1:0]    tbl_rd, win_rd, rd_next;

    irq_route_decode #(.ADDR_W(ADDR_W), .NUM_ENT(NUM_ENT)) u_dec (
        .addr(req_addr), .be(req_be), .sel(sel_q),
        .acc(acc), .idx(idx), .ent(ent), .half_hi(half_hi)
    );

    assign wr_sel = req_valid && req_write && acc == ACC_SEL;
    assign wr_win = req_valid && req_write && acc == ACC_WIN;
    assign tbl_wr = wr_win && idx == IDX_TBL;

    irq_route_table #(.NUM_ENT(NUM_ENT)) u_tbl (
        .clk(clk), .rst(rst), .wr_en(tbl_wr), .ent(ent), .half_hi(half_hi),
        .wdata(req_wdata), .rdata(tbl_rd), .flat(tbl_flat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            id_q  <= ID_W'(CPU_COUNT);
            arb_q <= ID_W'(CPU_COUNT);
        end else begin
            if (wr_sel) sel_q <= req_wdata[SEL_W-1:0];
            if (wr_win && idx == IDX_ID)  id_q  <= req_wdata[ID_LSB +: ID_W];
            if (wr_win && idx == IDX_ARB) arb_q <= req_wdata[ID_LSB +: ID_W];
        end
    end

    always_comb begin
        unique case (idx)
            IDX_ID:  win_rd = id_word(id_q);
            IDX_VER: win_rd = VER_WORD;
            IDX_ARB: win_rd = id_word(arb_q);
            IDX_TBL: win_rd = tbl_rd;
            default: win_rd = '0;
        endcase
    end

    always_comb begin
        rd_next = '0;
        if (req_valid && !req_write) begin
            if (acc == ACC_SEL)      rd_next = {{(DW-SEL_W){1'b0}}, sel_q};
            else if (acc == ACC_WIN) rd_next = win_rd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && acc == ACC_BAD;
            rsp_rdata <= rd_next;
        end
    end

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    // R2
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write && acc == ACC_SEL) |=> $stable(sel_q));
    // R1
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && rsp_rdata == '0));
    // R3
    id_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write && acc == ACC_WIN && idx == IDX_ID) |=> $stable(id_q));
    // R5
    arb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write && acc == ACC_WIN && idx == IDX_ARB) |=> $stable(arb_q));
    // R1
    bad_no_tbl_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && acc == ACC_BAD) |=> $stable(tbl_flat));

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_rsv
        // R7
        rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
            tbl_flat[i*64+17 +: 15] == '0 && tbl_flat[i*64+32 +: 24] == '0);
    end

endmodule

// File: tb/irq_route_regs_bench.sv
`timescale 1ns/1ps
module irq_route_regs_bench;
    localparam int NE = 24;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid, req_write;
    logic [7:0]    req_addr;
    logic [3:0]    req_be;
    logic [31:0]   req_wdata;
    logic          rsp_valid, rsp_err;
    logic [31:0]   rsp_rdata;
    logic [NE*64-1:0] tbl_flat;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_route_regs u_irq_route_regs (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .tbl_flat(tbl_flat)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [7:0] addr, input logic [3:0] be,
                       input logic [31:0] wd, output logic [31:0] rd,
                       output logic err, output logic vld);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_be = be; req_wdata = wd;
        @(negedge clk);
        rd = rsp_rdata; err = rsp_err; vld = rsp_valid;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_be = '0; req_wdata = '0;
    endtask

    task automatic set_sel(input logic [7:0] s);
        logic [31:0] rd; logic e, v;
        acc(1'b1, 8'd0, 4'hF, {24'h0, s}, rd, e, v);
    endtask

    task automatic win_wr(input logic [7:0] s, input logic [31:0] d);
        logic [31:0] rd; logic e, v;
        set_sel(s);
        acc(1'b1, 8'd16, 4'hF, d, rd, e, v);
    endtask

    task automatic win_rd(input logic [7:0] s, output logic [31:0] d);
        logic e, v;
        set_sel(s);
        acc(1'b0, 8'd16, 4'hF, 32'h0, d, e, v);
    endtask

    task automatic t_reset;
        logic [31:0] rd; logic e, v;
        chk("R8 rsp_valid idle after reset", {63'h0, rsp_valid}, 64'h0);
        chk("R8 table zero after reset", {63'h0, (tbl_flat == '0)}, 64'h1);
        acc(1'b0, 8'd0, 4'hF, 32'h0, rd, e, v);
        chk("R8 index reads zero", {32'h0, rd}, 64'h0);
        win_rd(8'h00, rd);
        chk("R8 id equals cpu count", {32'h0, rd}, 64'h0400_0000);
        win_rd(8'h02, rd);
        chk("R8 arb id equals cpu count", {32'h0, rd}, 64'h0400_0000);
    endtask

    task automatic t_select;
        logic [31:0] rd; logic e, v;
        acc(1'b1, 8'd0, 4'hF, 32'hDEAD_BE5A, rd, e, v);
        acc(1'b0, 8'd0, 4'hF, 32'h0, rd, e, v);
        chk("R2 index keeps low byte", {32'h0, rd}, 64'h5A);
        chk("R2 response strobe", {63'h0, v}, 64'h1);
        @(negedge clk);
        chk("R2 no response without request", {63'h0, rsp_valid}, 64'h0);
    endtask

    task automatic t_id_arb;
        logic [31:0] rd;
        win_wr(8'h00, 32'hFA5A_5A5A);
        win_wr(8'h02, 32'h0300_0000);
        win_rd(8'h00, rd);
        chk("R3 id bits 27:24 only", {32'h0, rd}, 64'h0A00_0000);
        win_rd(8'h02, rd);
        chk("R5 arb id separate", {32'h0, rd}, 64'h0300_0000);
    endtask

    task automatic t_version;
        logic [31:0] rd;
        win_rd(8'h01, rd);
        chk("R4 version word", {32'h0, rd}, 64'h0017_0011);
        win_wr(8'h01, 32'hFFFF_FFFF);
        win_rd(8'h01, rd);
        chk("R4 version after write", {32'h0, rd}, 64'h0017_0011);
    endtask

    task automatic t_table;
        logic [31:0] rd;
        win_wr(8'h1A, 32'h0000_1234);
        win_wr(8'h1B, 32'h5C00_0000);
        chk("R6 entry 5 low on output", {32'h0, tbl_flat[5*64 +: 32]}, 64'h1234);
        chk("R6 entry 5 high on output", {32'h0, tbl_flat[5*64+32 +: 32]}, 64'h5C00_0000);
        win_rd(8'h1B, rd);
        chk("R6 entry 5 high readback", {32'h0, rd}, 64'h5C00_0000);
        win_rd(8'h1A, rd);
        chk("R6 entry 5 low readback", {32'h0, rd}, 64'h1234);
    endtask

    task automatic t_reserved;
        logic [31:0] rd;
        win_wr(8'h10, 32'hFFFF_FFFF);
        win_rd(8'h10, rd);
        chk("R7 low word scrub", {32'h0, rd}, 64'h0001_FFFF);
        win_wr(8'h3F, 32'hABFF_FFFF);
        win_rd(8'h3F, rd);
        chk("R7 last high word scrub", {32'h0, rd}, 64'hAB00_0000);
        chk("R6 last entry high on output", {32'h0, tbl_flat[23*64+32 +: 32]}, 64'hAB00_0000);
    endtask

    task automatic t_undefined;
        logic [31:0] rd;
        logic [NE*64-1:0] snap;
        snap = tbl_flat;
        win_wr(8'h05, 32'hFFFF_FFFF);
        win_rd(8'h05, rd);
        chk("R9 gap index reads zero", {32'h0, rd}, 64'h0);
        win_wr(8'h40, 32'hFFFF_FFFF);
        win_rd(8'h40, rd);
        chk("R9 past-table index reads zero", {32'h0, rd}, 64'h0);
        chk("R9 table untouched", {63'h0, (tbl_flat == snap)}, 64'h1);
        win_rd(8'h00, rd);
        chk("R9 id untouched", {32'h0, rd}, 64'h0A00_0000);
        win_rd(8'h02, rd);
        chk("R9 arb id untouched", {32'h0, rd}, 64'h0300_0000);
    endtask

    task automatic t_illegal;
        logic [31:0] rd; logic e, v;
        logic [NE*64-1:0] snap;
        set_sel(8'h1A);
        acc(1'b1, 8'd4, 4'hF, 32'h0000_0011, rd, e, v);
        chk("R1 bad offset flags error", {62'h0, v, e}, 64'h3);
        acc(1'b0, 8'd8, 4'hF, 32'h0, rd, e, v);
        chk("R1 bad offset read error", {31'h0, e, rd}, {31'h0, 1'b1, 32'h0});
        acc(1'b1, 8'd0, 4'h7, 32'h0000_0022, rd, e, v);
        chk("R1 partial enable error", {63'h0, e}, 64'h1);
        acc(1'b0, 8'd0, 4'hF, 32'h0, rd, e, v);
        chk("R1 index unchanged", {32'h0, rd}, 64'h1A);
        snap = tbl_flat;
        acc(1'b1, 8'd16, 4'h3, 32'h0000_7777, rd, e, v);
        chk("R1 partial window write error", {63'h0, e}, 64'h1);
        chk("R1 table unchanged", {63'h0, (tbl_flat == snap)}, 64'h1);
    endtask

    task automatic t_write_resp;
        logic [31:0] rd; logic e, v;
        set_sel(8'h20);
        acc(1'b1, 8'd16, 4'hF, 32'h0000_00FF, rd, e, v);
        chk("R10 write response", {31'h0, v, e, rd}, {31'h0, 1'b1, 1'b0, 32'h0});
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            report();
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_be = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_select();
        t_id_arb();
        t_version();
        t_table();
        t_reserved();
        t_undefined();
        t_illegal();
        t_write_resp();
        done = 1;
        report();
    end

endmodule